// File: doc/BRIEF.md
# Backplane Link Bring-Up Sequencer

This controller walks a single backplane port from reset to an operating data path. After power is good it starts a speed negotiation, waits for the negotiation engine to report a result, and resolves the fastest speed that both ends offer. The 10G-KR speed always goes through link training before its data path is enabled. The 1G-KX speed goes straight to its data path without training. A legacy 1G-KX partner that cannot negotiate is caught by a parallel-detect input, and the block moves directly to 1G-KX data mode.

The page exchange, the training algorithm and the SERDES lie outside this block. They talk to it through start pulses and done strobes. Once a data mode is running, a loss of link sends the port back to negotiation, so the whole sequence runs again. Link status passes through a two-flop synchronizer before the state machine uses it.

States: IDLE (0), AN (1), TRAIN (2), DATA_KR (3), DATA_KX (4). Transitions:
- IDLE→AN when power is good.
- AN→TRAIN when the result is 10G-KR.
- AN→DATA_KX when the result is 1G-KX, or on parallel detect.
- AN→AN when the result has no common mode.
- TRAIN→DATA_KR when training is done.
- DATA_KR/DATA_KX→AN on link loss.
- Any state→IDLE when power is lost or on a software reset.

Top module: `bplane_bringup_ctrl`

## Requirements
- R1: During and after reset, state_o is 0 (IDLE), an_start_o, tr_start_o and dp_en_o are 0, speed_kr_o is 1, and the local advertisement holds 10G-KR only (bit 0 = 10G-KR, bit 1 = 1G-KX).
- R2: In IDLE with pwr_good_i high, the next clock edge moves state_o to 1 (AN) and raises an_start_o for exactly one cycle.
- R3: When an_done_i is high in AN, the common set is the local advertisement ANDed with lp_ability_i. If the common set contains 10G-KR, the same edge moves state_o to 2 (TRAIN) and pulses tr_start_o for one cycle.
- R4: When the common set contains 1G-KX but not 10G-KR, the block enters DATA_KX (4) with speed_kr_o at 0 and dp_en_o at 1, and tr_start_o stays 0.
- R5: When the common set is empty, state_o stays 1 (AN) and dp_en_o stays 0.
- R6: In TRAIN, tr_done_i moves state_o to 3 (DATA_KR) with speed_kr_o at 1 and dp_en_o at 1. dp_en_o is 1 only in states 3 and 4.
- R7: In DATA_KR or DATA_KX, a low on link_ok_i returns state_o to 1 (AN) with an an_start_o pulse on the third rising edge after the input falls, because of the two synchronizer stages. dp_en_o falls on that same edge.
- R8: pd_kx_i high in AN moves the block to DATA_KX (speed_kr_o 0, dp_en_o 1) and tr_start_o is never pulsed.
- R9: pwr_good_i low or sw_reset_i high forces state_o to 0 (IDLE) on the next edge from any state. The advertisement is kept, and negotiation restarts once power is good and the software reset is released.
- R10: A cycle with adv_wr_i high loads adv_i into the local advertisement used by later resolutions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| pwr_good_i | input | 1 | Power is good |
| sw_reset_i | input | 1 | Software reset request |
| adv_wr_i | input | 1 | Load strobe for the advertisement |
| adv_i | input | 2 | New advertisement (bit0 10G-KR, bit1 1G-KX) |
| an_done_i | input | 1 | Negotiation result strobe |
| lp_ability_i | input | 2 | Partner abilities that arrive with the strobe |
| pd_kx_i | input | 1 | Parallel detect found a legacy 1G-KX partner |
| tr_done_i | input | 1 | Link training completed |
| link_ok_i | input | 1 | Link status (asynchronous) |
| an_start_o | output | 1 | One-cycle negotiation start pulse |
| tr_start_o | output | 1 | One-cycle training start pulse |
| speed_kr_o | output | 1 | 1 = 10G-KR selected, 0 = 1G-KX |
| dp_en_o | output | 1 | Data path enable |
| state_o | output | 3 | Current state code |

## Verification
The bench tries every local advertisement against every partner ability set, including the reset default. A resolver with the wrong priority would show up as DATA_KX where TRAIN was expected. A resolver that ignores the empty case would enable a data path while it should stay in AN. Link loss is timed to the exact edge, so a design with one synchronizer stage too many or too few reacts a cycle off. The parallel-detect, software-reset and power-loss paths are driven from the middle of the sequence. A design that trains on a legacy partner, or that does not return to IDLE, is caught at the pulse and state outputs.

// File: rtl/bub_pkg.sv
package bub_pkg;
    localparam int NUM_SPEEDS = 2;
    localparam int SPD_KR     = 0;
    localparam int SPD_KX     = 1;
    localparam int STATE_W    = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_AN      = 3'd1,
        ST_TRAIN   = 3'd2,
        ST_DATA_KR = 3'd3,
        ST_DATA_KX = 3'd4
    } bub_state_e;
endpackage

// File: rtl/bub_sync.sv
module bub_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bub_resolve.sv
module bub_resolve #(
    parameter int N = 2
) (
    input  logic [N-1:0] common_i,
    output logic [N-1:0] grant_o,
    output logic         valid_o
);
    // Lowest index has the highest priority (fastest speed first).
    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign grant_o[i] = common_i[i];
        end else begin : g_low
            assign grant_o[i] = common_i[i] & ~(|common_i[i-1:0]);
        end
    end

    assign valid_o = |common_i;
endmodule

// File: rtl/bub_fsm.sv
module bub_fsm
    import bub_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good_i,
    input  logic               sw_reset_i,
    input  logic               an_done_i,
    input  logic               res_valid_i,
    input  logic               res_kr_i,
    input  logic               pd_kx_i,
    input  logic               tr_done_i,
    input  logic               link_ok_i,
    output logic               an_start_o,
    output logic               tr_start_o,
    output logic               speed_kr_o,
    output logic               dp_en_o,
    output logic [STATE_W-1:0] state_o
);
    bub_state_e state_q;
    bub_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!pwr_good_i || sw_reset_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_AN;
                end
                ST_AN: begin
                    if (an_done_i && res_valid_i) begin
                        state_d = res_kr_i ? ST_TRAIN : ST_DATA_KX;
                    end else if (!an_done_i && pd_kx_i) begin
                        state_d = ST_DATA_KX;
                    end
                end
                ST_TRAIN: begin
                    if (tr_done_i) begin
                        state_d = ST_DATA_KR;
                    end
                end
                ST_DATA_KR, ST_DATA_KX: begin
                    if (!link_ok_i) begin
                        state_d = ST_AN;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            an_start_o <= 1'b0;
            tr_start_o <= 1'b0;
            speed_kr_o <= 1'b1;
            dp_en_o    <= 1'b0;
        end else begin
            an_start_o <= (state_d == ST_AN)    && (state_q != ST_AN);
            tr_start_o <= (state_d == ST_TRAIN) && (state_q != ST_TRAIN);
            dp_en_o    <= (state_d == ST_DATA_KR) || (state_d == ST_DATA_KX);
            if (state_d == ST_TRAIN || state_d == ST_DATA_KR) begin
                speed_kr_o <= 1'b1;
            end else if (state_d == ST_DATA_KX) begin
                speed_kr_o <= 1'b0;
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/bplane_bringup_ctrl.sv
module bplane_bringup_ctrl
    import bub_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_good_i,
    input  logic                  sw_reset_i,
    input  logic                  adv_wr_i,
    input  logic [NUM_SPEEDS-1:0] adv_i,
    input  logic                  an_done_i,
    input  logic [NUM_SPEEDS-1:0] lp_ability_i,
    input  logic                  pd_kx_i,
    input  logic                  tr_done_i,
    input  logic                  link_ok_i,
    output logic                  an_start_o,
    output logic                  tr_start_o,
    output logic                  speed_kr_o,
    output logic                  dp_en_o,
    output logic [STATE_W-1:0]    state_o
);
    localparam logic [NUM_SPEEDS-1:0] ADV_RESET = NUM_SPEEDS'(1) << SPD_KR;

    logic [NUM_SPEEDS-1:0] adv_q;
    logic [NUM_SPEEDS-1:0] grant;
    logic                  res_valid;
    logic                  link_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adv_q <= ADV_RESET;
        end else if (adv_wr_i) begin
            adv_q <= adv_i;
        end
    end

    bub_sync #(.STAGES(SYNC_STAGES)) u_link_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (link_ok_i),
        .q_o   (link_s)
    );

    bub_resolve #(.N(NUM_SPEEDS)) u_resolve (
        .common_i (adv_q & lp_ability_i),
        .grant_o  (grant),
        .valid_o  (res_valid)
    );

    bub_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good_i  (pwr_good_i),
        .sw_reset_i  (sw_reset_i),
        .an_done_i   (an_done_i),
        .res_valid_i (res_valid),
        .res_kr_i    (grant[SPD_KR]),
        .pd_kx_i     (pd_kx_i),
        .tr_done_i   (tr_done_i),
        .link_ok_i   (link_s),
        .an_start_o  (an_start_o),
        .tr_start_o  (tr_start_o),
        .speed_kr_o  (speed_kr_o),
        .dp_en_o     (dp_en_o),
        .state_o     (state_o)
    );
endmodule

// File: rtl/bub_chk.sv
module bub_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good_i,
    input logic       sw_reset_i,
    input logic       an_start_o,
    input logic       tr_start_o,
    input logic       speed_kr_o,
    input logic       dp_en_o,
    input logic [2:0] state_o
);
    // R2
    an_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_start_o |-> (state_o == 3'd1) && !$past(an_start_o));
    // R3
    tr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_start_o |-> (state_o == 3'd2) && ($past(state_o) == 3'd1));
    // R4
    kx_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> !speed_kr_o);
    // R6
    dp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_en_o == ((state_o == 3'd3) || (state_o == 3'd4)));
    // R6
    kr_train_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd3) && ($past(state_o) != 3'd3)) |-> ($past(state_o) == 3'd2));
    // R9
    idle_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good_i || sw_reset_i) |=> (state_o == 3'd0));
    // R8
    kx_no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd4) && ($past(state_o) != 3'd4)) |-> ($past(state_o) == 3'd1));
endmodule

bind bplane_bringup_ctrl bub_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good_i),
    .sw_reset_i (sw_reset_i),
    .an_start_o (an_start_o),
    .tr_start_o (tr_start_o),
    .speed_kr_o (speed_kr_o),
    .dp_en_o    (dp_en_o),
    .state_o    (state_o)
);

// File: tb/sim_bplane_bringup_ctrl.sv
`timescale 1ns/1ps
module sim_bplane_bringup_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good_i = 1'b0, sw_reset_i = 1'b0, adv_wr_i = 1'b0;
    logic [1:0] adv_i = 2'b00, lp_ability_i = 2'b00;
    logic       an_done_i = 1'b0, pd_kx_i = 1'b0, tr_done_i = 1'b0, link_ok_i = 1'b1;
    logic       an_start_o, tr_start_o, speed_kr_o, dp_en_o;
    logic [2:0] state_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bplane_bringup_ctrl u0 (.*);

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwr_good_i = 1'b0; sw_reset_i = 1'b0; adv_wr_i = 1'b0;
        an_done_i = 1'b0; pd_kx_i = 1'b0; tr_done_i = 1'b0; link_ok_i = 1'b1;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic reach_an();
        pwr_good_i = 1'b1;
        step(1);
        check("R2 state", state_o, 1);
        check("R2 an_start", an_start_o, 1);
        step(1);
        check("R2 pulse width", an_start_o, 0);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 dp_en", dp_en_o, 0);
        check("R1 speed", speed_kr_o, 1);
        check("R1 an_start", an_start_o, 0);
        check("R1 tr_start", tr_start_o, 0);

        // Sweep: cfg 0..3 writes that advertisement (R10), cfg 4 keeps reset default (R1)
        for (int cfg = 0; cfg < 5; cfg++) begin
            for (int lp = 0; lp < 4; lp++) begin
                logic [1:0] adv, com;
                do_reset();
                if (cfg < 4) begin
                    adv_wr_i = 1'b1; adv_i = 2'(cfg);
                    step(1);
                    adv_wr_i = 1'b0;
                    adv = 2'(cfg);
                end else begin
                    adv = 2'b01;
                end
                com = adv & 2'(lp);
                reach_an();
                an_done_i = 1'b1; lp_ability_i = 2'(lp);
                step(1);
                an_done_i = 1'b0;
                if (com[0]) begin
                    // R3 KR wins priority, training starts the next cycle
                    check("R3 state", state_o, 2);
                    check("R3 tr_start", tr_start_o, 1);
                    check("R6 dp_en in TRAIN", dp_en_o, 0);
                    step(1);
                    check("R3 tr pulse width", tr_start_o, 0);
                    tr_done_i = 1'b1;
                    step(1);
                    tr_done_i = 1'b0;
                    check("R6 state", state_o, 3);
                    check("R6 dp_en", dp_en_o, 1);
                    check("R6 speed", speed_kr_o, 1);
                end else if (com[1]) begin
                    check("R4 state", state_o, 4);
                    check("R4 speed", speed_kr_o, 0);
                    check("R4 dp_en", dp_en_o, 1);
                    check("R4 no tr_start", tr_start_o, 0);
                end else begin
                    check("R5 state", state_o, 1);
                    check("R5 dp_en", dp_en_o, 0);
                    step(2);
                    check("R5 still AN", state_o, 1);
                end
            end
        end

        // R7 link loss in DATA_KR, exact edge
        do_reset();
        reach_an();
        an_done_i = 1'b1; lp_ability_i = 2'b11;
        step(1);
        an_done_i = 1'b0; tr_done_i = 1'b1;
        step(1);
        tr_done_i = 1'b0;
        check("R7 in DATA_KR", state_o, 3);
        link_ok_i = 1'b0;
        step(2);
        check("R7 held two edges", state_o, 3);
        check("R7 dp_en held", dp_en_o, 1);
        step(1);
        check("R7 back to AN", state_o, 1);
        check("R7 an_start", an_start_o, 1);
        check("R7 dp_en off", dp_en_o, 0);
        link_ok_i = 1'b1;
        // rerun sequence after restart, KR again
        an_done_i = 1'b1;
        step(1);
        an_done_i = 1'b0;
        check("R7 retrain", state_o, 2);

        // R8 parallel detect from AN, then R7 link loss in DATA_KX
        do_reset();
        reach_an();
        pd_kx_i = 1'b1;
        step(1);
        pd_kx_i = 1'b0;
        check("R8 state", state_o, 4);
        check("R8 speed", speed_kr_o, 0);
        check("R8 dp_en", dp_en_o, 1);
        check("R8 no tr_start", tr_start_o, 0);
        link_ok_i = 1'b0;
        step(3);
        check("R7 KX back to AN", state_o, 1);
        link_ok_i = 1'b1;

        // R9 software reset from DATA_KX keeps advertisement
        do_reset();
        adv_wr_i = 1'b1; adv_i = 2'b10;
        step(1);
        adv_wr_i = 1'b0;
        reach_an();
        an_done_i = 1'b1; lp_ability_i = 2'b11;
        step(1);
        an_done_i = 1'b0;
        check("R10 KX by adv", state_o, 4);
        sw_reset_i = 1'b1;
        step(1);
        sw_reset_i = 1'b0;
        check("R9 sw reset idle", state_o, 0);
        check("R9 dp_en", dp_en_o, 0);
        step(1);
        check("R9 restart AN", state_o, 1);
        check("R9 an_start", an_start_o, 1);
        an_done_i = 1'b1; lp_ability_i = 2'b11;
        step(1);
        an_done_i = 1'b0;
        check("R9 adv kept", state_o, 4);

        // R9 power loss from TRAIN
        do_reset();
        reach_an();
        an_done_i = 1'b1; lp_ability_i = 2'b01;
        step(1);
        an_done_i = 1'b0;
        pwr_good_i = 1'b0;
        step(1);
        check("R9 power loss idle", state_o, 0);
        step(2);
        check("R9 idle while unpowered", state_o, 0);
        check("R9 no an_start", an_start_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule